// File: doc/BRIEF.md
# I2C Dual Digital-Potentiometer Controller

This block is the digital side of a two-channel digital potentiometer that is set up over an I2C-compatible two-wire bus. It runs entirely in the system clock domain. SCL and SDA are oversampled through synchronizers, and START and STOP conditions and SCL edges are found on the synchronized copies. The block drives the bus only through an open-drain pull-low enable. It holds two 8-bit wiper codes, a shutdown flag for each channel and two general-purpose logic outputs.

A write transaction has three bytes. The first is the address byte with R/W low. The second is a command byte that selects the channel, can force the wiper of that channel to mid-scale, sets that channel's shutdown flag and sets the two logic outputs. The third is the data byte, which becomes the selected wiper code. A read transaction has only the address byte with R/W high. The block then shifts out the code of the channel chosen by the most recent command byte. Two strap inputs form the low address bits, so up to four such blocks can share one bus.

Top module: `dpot_i2c_ctrl`

## Requirements
- R1: The block acknowledges (drives SDA low during the ninth SCL clock) an address byte whose upper seven bits equal binary 01011 followed by strap_i[1], strap_i[0]. Bit 0 of the address byte is R/W, with 0 meaning write.
- R2: After an address byte that does not match, the block never drives SDA, and no output changes until the next START or STOP.
- R3: In a write, the command byte and the data byte are each acknowledged. The data byte is loaded into the wiper of the channel chosen by command bit 7 (0 selects wiper0_o, 1 selects wiper1_o).
- R4: Command bit 6 set forces the selected wiper to 0x80 when the command byte is acknowledged. A data byte that follows in the same write still overwrites that wiper.
- R5: Command bit 5 sets or clears the shutdown flag of the selected channel (off_o[0] for channel 1, off_o[1] for channel 2). Driving shdn_n_i low raises both bits of off_o while it is low.
- R6: Command bit 4 drives gpo_o[1] and command bit 3 drives gpo_o[0]. Command bits 2 to 0 have no effect.
- R7: In a read, the block shifts out the selected channel's wiper code MSB first, one bit for each SCL clock. It releases SDA for the master's ninth-clock response and does not drive it afterwards.
- R8: After reset, both wipers are 0x80, off_o and gpo_o are 0, SDA is released and a read returns channel 1.
- R9: The pull-low enable changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 2 | Low two bits of the bus address |
| shdn_n_i | input | 1 | Active-low shutdown pin, acts on both channels |
| sda_pull_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| wiper0_o | output | 8 | Wiper code of channel 1 |
| wiper1_o | output | 8 | Wiper code of channel 2 |
| off_o | output | 2 | Shutdown state per channel (bit 0 channel 1) |
| gpo_o | output | 2 | General-purpose logic outputs |

## Verification
The assertions check on every cycle that the pull-low enable moves only while synchronized SCL is low, and that it stays off in the ignore state. They also check that any change of a wiper code, of the logic outputs, or of a shutdown flag while the pin is steady happens in the very cycle an acknowledge begins. Those checks cannot tell whether the right channel, the right value or the right address was used. The bench's transaction table and directed reads show mid-scale followed by an overwrite, the masked low command bits, the shutdown pin forcing both channels, and the channel that a read returns after a write of only a command byte.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
   localparam int CODE_W  = 8;
   localparam int NUM_CH  = 2;
   localparam int CNT_W   = $clog2(CODE_W);
   localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

   // command byte field positions (bus-visible, fixed)
   localparam int CMD_SEL = 7;
   localparam int CMD_MID = 6;
   localparam int CMD_OFF = 5;
   localparam int CMD_G1  = 4;
   localparam int CMD_G0  = 3;

   typedef enum logic [3:0] {
      ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK,
      ST_DATA, ST_DATA_ACK, ST_RD, ST_RD_ACK, ST_IGNORE
   } bus_st_e;
endpackage

// File: rtl/dpot_sync.sv
module dpot_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_depth
      $error("dpot_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[0] <= RST_VAL;
            else        chain[0] <= d_i;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[i] <= RST_VAL;
            else        chain[i] <= chain[i-1];
      end
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/dpot_bus_cond.sv
module dpot_bus_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_c,
   output logic stop_c
);
   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end

   assign scl_rise = scl_s & ~scl_d;
   assign scl_fall = ~scl_s & scl_d;
   assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/dpot_engine.sv
module dpot_engine
   import dpot_pkg::*;
#(
   parameter logic [4:0] ADDR_HI = 5'b01011
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          scl_rise,
   input  logic                          scl_fall,
   input  logic                          start_c,
   input  logic                          stop_c,
   input  logic                          sda_s,
   input  logic [1:0]                    strap,
   output logic                          pull,
   output logic [NUM_CH-1:0][CODE_W-1:0] code,
   output logic [NUM_CH-1:0]             sd,
   output logic [1:0]                    gpo,
   output bus_st_e                       st
);
   logic [CODE_W-1:0] sr;
   logic [CODE_W-1:0] tx;
   logic [CNT_W-1:0]  cnt;
   logic              byte_done;
   logic              rw;
   logic              sel;
   logic              addr_hit;

   assign addr_hit = (sr[CODE_W-1:1] == {ADDR_HI, strap});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         sr        <= '0;
         tx        <= '0;
         cnt       <= '0;
         byte_done <= 1'b0;
         rw        <= 1'b0;
         sel       <= 1'b0;
         pull      <= 1'b0;
         code      <= {NUM_CH{MID_CODE}};
         sd        <= '0;
         gpo       <= '0;
      end else if (start_c) begin
         st        <= ST_ADDR;
         cnt       <= '0;
         byte_done <= 1'b0;
         pull      <= 1'b0;
      end else if (stop_c) begin
         st        <= ST_IDLE;
         byte_done <= 1'b0;
         pull      <= 1'b0;
      end else begin
         unique case (st)
            ST_ADDR, ST_CMD, ST_DATA: begin
               if (scl_rise) begin
                  sr  <= {sr[CODE_W-2:0], sda_s};
                  cnt <= cnt + 1'b1;
                  if (cnt == CNT_W'(CODE_W - 1)) byte_done <= 1'b1;
               end else if (scl_fall && byte_done) begin
                  byte_done <= 1'b0;
                  if (st == ST_ADDR) begin
                     if (addr_hit) begin
                        rw   <= sr[0];
                        pull <= 1'b1;
                        st   <= ST_ADDR_ACK;
                     end else begin
                        st   <= ST_IGNORE;
                     end
                  end else if (st == ST_CMD) begin
                     sel            <= sr[CMD_SEL];
                     sd[sr[CMD_SEL]] <= sr[CMD_OFF];
                     gpo            <= {sr[CMD_G1], sr[CMD_G0]};
                     if (sr[CMD_MID]) code[sr[CMD_SEL]] <= MID_CODE;
                     pull           <= 1'b1;
                     st             <= ST_CMD_ACK;
                  end else begin
                     code[sel] <= sr;
                     pull      <= 1'b1;
                     st        <= ST_DATA_ACK;
                  end
               end
            end
            ST_ADDR_ACK: begin
               if (scl_fall) begin
                  if (rw) begin
                     tx   <= code[sel];
                     pull <= ~code[sel][CODE_W-1];
                     cnt  <= '0;
                     st   <= ST_RD;
                  end else begin
                     pull <= 1'b0;
                     cnt  <= '0;
                     st   <= ST_CMD;
                  end
               end
            end
            ST_CMD_ACK: begin
               if (scl_fall) begin
                  pull <= 1'b0;
                  cnt  <= '0;
                  st   <= ST_DATA;
               end
            end
            ST_DATA_ACK: begin
               if (scl_fall) begin
                  pull <= 1'b0;
                  st   <= ST_IGNORE;
               end
            end
            ST_RD: begin
               if (scl_fall) begin
                  if (cnt == CNT_W'(CODE_W - 1)) begin
                     pull <= 1'b0;
                     st   <= ST_RD_ACK;
                  end else begin
                     tx   <= {tx[CODE_W-2:0], 1'b0};
                     pull <= ~tx[CODE_W-2];
                     cnt  <= cnt + 1'b1;
                  end
               end
            end
            ST_RD_ACK: begin
               if (scl_fall) st <= ST_IGNORE;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/dpot_i2c_ctrl.sv
module dpot_i2c_ctrl
   import dpot_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter logic [4:0] ADDR_HI     = 5'b01011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [1:0]        strap_i,
   input  logic              shdn_n_i,
   output logic              sda_pull_o,
   output logic [CODE_W-1:0] wiper0_o,
   output logic [CODE_W-1:0] wiper1_o,
   output logic [1:0]        off_o,
   output logic [1:0]        gpo_o
);
   if (NUM_CH != 2) begin : g_bad_ch
      $error("dpot_i2c_ctrl: the command byte addresses exactly two channels");
   end

   logic scl_s, sda_s;
   logic scl_rise, scl_fall, start_c, stop_c;
   logic [NUM_CH-1:0][CODE_W-1:0] code;
   logic [NUM_CH-1:0]             sd;
   bus_st_e st;

   dpot_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s));

   dpot_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s));

   dpot_bus_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_c(start_c), .stop_c(stop_c));

   dpot_engine #(.ADDR_HI(ADDR_HI)) u_eng (
      .clk(clk), .rst_n(rst_n),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_c(start_c), .stop_c(stop_c),
      .sda_s(sda_s), .strap(strap_i),
      .pull(sda_pull_o), .code(code), .sd(sd), .gpo(gpo_o), .st(st));

   assign wiper0_o = code[0];
   assign wiper1_o = code[1];
   assign off_o    = sd | {NUM_CH{~shdn_n_i}};
endmodule

// File: rtl/dpot_i2c_ctrl_chk.sv
module dpot_i2c_ctrl_chk
   import dpot_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        scl_s,
   input bus_st_e     st,
   input logic        sda_pull_o,
   input logic        shdn_n_i,
   input logic [7:0]  wiper0_o,
   input logic [7:0]  wiper1_o,
   input logic [1:0]  off_o,
   input logic [1:0]  gpo_o
);
   // R9
   pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull_o) |-> $past(!scl_s));

   // R2
   ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IGNORE) |-> !sda_pull_o);

   // R3
   wiper_at_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(wiper0_o) || !$stable(wiper1_o)) |-> $rose(sda_pull_o));

   // R6
   gpo_at_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(gpo_o) |-> $rose(sda_pull_o));

   // R5
   off_at_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(off_o) && $stable(shdn_n_i)) |-> $rose(sda_pull_o));
endmodule

bind dpot_i2c_ctrl dpot_i2c_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .st(st),
   .sda_pull_o(sda_pull_o), .shdn_n_i(shdn_n_i),
   .wiper0_o(wiper0_o), .wiper1_o(wiper1_o),
   .off_o(off_o), .gpo_o(gpo_o));

// File: tb/dpot_i2c_ctrl_bench.sv
module dpot_i2c_ctrl_bench;
   localparam int Q = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1;
   logic       m_sda = 1'b1;
   logic [1:0] strap = 2'b10;
   logic       shdn_n = 1'b1;
   logic       sda_pull;
   logic [7:0] w0, w1;
   logic [1:0] off, gpo;
   logic       sda_line;
   int         n_chk = 0;
   int         n_bad = 0;
   bit         done = 1'b0;

   always #4 clk = ~clk;

   assign sda_line = m_sda & ~sda_pull;

   dpot_i2c_ctrl u_dpot_i2c_ctrl (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
      .strap_i(strap), .shdn_n_i(shdn_n), .sda_pull_o(sda_pull),
      .wiper0_o(w0), .wiper1_o(w1), .off_o(off), .gpo_o(gpo));

   // {address byte, command, data, exp w0, exp w1, exp off, exp gpo, exp ack}
   localparam logic [44:0] VEC [6] = '{
      {8'h5C, 8'h00, 8'h3A, 8'h3A, 8'h80, 2'b00, 2'b00, 1'b1},
      {8'h5C, 8'h80, 8'hC5, 8'h3A, 8'hC5, 2'b00, 2'b00, 1'b1},
      {8'h5C, 8'h18, 8'h00, 8'h00, 8'hC5, 2'b00, 2'b11, 1'b1},
      {8'h5C, 8'hA7, 8'hFF, 8'h00, 8'hFF, 2'b10, 2'b00, 1'b1},
      {8'h5C, 8'h48, 8'h5B, 8'h5B, 8'hFF, 2'b10, 2'b01, 1'b1},
      {8'h58, 8'h00, 8'h11, 8'h5B, 8'hFF, 2'b10, 2'b01, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; m_scl = 1'b1; wq();
      m_sda = 1'b0; wq();
      m_scl = 1'b0; wq();
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wq();
      m_scl = 1'b1; wq();
      m_sda = 1'b1; wq();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         m_sda = b[i]; wq();
         m_scl = 1'b1; wq(); wq();
         m_scl = 1'b0; wq();
      end
      m_sda = 1'b1; wq();
      m_scl = 1'b1; wq();
      ack = ~sda_line;
      wq();
      m_scl = 1'b0; wq();
   endtask

   task automatic read_byte(output logic [7:0] b);
      m_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wq();
         m_scl = 1'b1; wq();
         b[i] = sda_line;
         wq();
         m_scl = 1'b0;
      end
      wq();
      m_scl = 1'b1; wq(); wq();   // master not-acknowledge
      m_scl = 1'b0; wq();
   endtask

   task automatic do_read(input logic [7:0] addr, input logic exp_ack,
                          input logic [7:0] exp_b, input string req);
      logic a;
      logic [7:0] b;
      bus_start();
      send_byte(addr, a);
      chk({req, " read address ack"}, a, exp_ack);
      read_byte(b);
      chk({req, " read data"}, b, exp_b);
      chk("R7 SDA released after read", sda_pull, 1'b0);
      bus_stop();
   endtask

   initial begin
      logic a;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R8 reset state
      chk("R8 wiper0 at reset", w0, 8'h80);
      chk("R8 wiper1 at reset", w1, 8'h80);
      chk("R8 off at reset", off, 2'b00);
      chk("R8 gpo at reset", gpo, 2'b00);
      chk("R8 SDA released at reset", sda_pull, 1'b0);
      do_read(8'h5D, 1'b1, 8'h80, "R8");

      // table: R1 R2 R3 R4 R5 R6
      foreach (VEC[k]) begin
         bus_start();
         send_byte(VEC[k][44:37], a);
         chk("R1/R2 address ack", a, VEC[k][0]);
         send_byte(VEC[k][36:29], a);
         chk("R3 command ack", a, VEC[k][0]);
         send_byte(VEC[k][28:21], a);
         chk("R3 data ack", a, VEC[k][0]);
         bus_stop();
         chk("R3/R4 wiper0", w0, VEC[k][20:13]);
         chk("R3 wiper1", w1, VEC[k][12:5]);
         chk("R5 off", off, VEC[k][4:3]);
         chk("R6 gpo", gpo, VEC[k][2:1]);
      end

      // R7 read of channel selected by last matched command (channel 1)
      do_read(8'h5D, 1'b1, 8'h5B, "R7 ch1");

      // R4 command only: select ch2 with mid-scale, clears its shutdown
      bus_start();
      send_byte(8'h5C, a);
      send_byte(8'hC0, a);
      chk("R4 command-only ack", a, 1'b1);
      bus_stop();
      chk("R4 mid-scale wiper1", w1, 8'h80);
      chk("R4 wiper0 untouched", w0, 8'h5B);
      chk("R5 off cleared", off, 2'b00);
      do_read(8'h5D, 1'b1, 8'h80, "R7 ch2");

      // R2 mismatched read drives nothing
      do_read(8'h59, 1'b0, 8'hFF, "R2");

      // R1 other strap value
      strap = 2'b01;
      do_read(8'h5B, 1'b1, 8'h80, "R1 strap 01");

      // R5 shutdown pin
      shdn_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R5 pin low forces off", off, 2'b11);
      shdn_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R5 pin high releases", off, 2'b00);

      // R8 reset restores mid-scale
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R8 wiper0 after reset", w0, 8'h80);
      do_read(8'h5B, 1'b1, 8'h80, "R8 ch1 after reset");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule